// File: doc/BRIEF.md
# 8-bit ALU with status flags

This block is the arithmetic and logic core of a small 8-bit processor datapath. Each cycle it takes two operands, a 5-bit operation code, a flag index and an enable. It returns the result and a write-enable for that result, plus the status byte that the operation produces. Operations with no destination leave the write-enable low. These are the compares, the single-flag set and clear, and the unused codes.

The status byte sits in a register inside the block. It loads the computed next value on every rising edge where `op_en` is high. That register's value is the flag input to the next operation, so a carry chain across several bytes works with no help from outside. Each operation changes only its own fixed subset of flags and carries every other bit over unchanged.

Decode of instructions, the register file, memory, multiply and word-wide arithmetic live elsewhere in the chip.

Top module: `alu8_status_unit`

## Requirements
- R1: After reset `status_q` is 0x00. While `op_en` is low, `result_we` is 0, `status_next` equals `status_q` and the status register keeps its value.
- R2: Status bit positions are C=0, Z=1, N=2, V=3, S=4, H=5, T=6, I=7. `status_q` takes `status_next` at each rising edge with `op_en` high. Every operation that updates N or V sets S to N XOR V.
- R3: ADD (code 0) and ADC (code 1) write A+B (ADC: A+B+C). They set C to the carry out of bit 7, H to the carry out of bit 3, V to signed overflow, N to result bit 7 and Z to result==0. I and T are kept.
- R4: SUB (code 2) and SBC (code 3) write A-B (SBC: A-B-C). They set C to the borrow out of bit 7, H to the borrow into bit 4 from bit 3, V to signed overflow, and N from the result. SUB sets Z to result==0. SBC sets Z only when the result is zero and Z was already 1.
- R5: CP (code 4) and CPC (code 5) set the flags exactly as SUB and SBC do, and keep `result_we` at 0.
- R6: AND (code 6), OR (code 7) and XOR (code 8) write the bitwise result, set Z and N, force V to 0 and keep C and H.
- R7: COM (code 9) writes 0xFF-A and sets C=1 and V=0. NEG (code 10) writes 0x00-A and sets C=(A!=0), V=(A==0x80) and H to the borrow into bit 4. Both set Z and N.
- R8: INC (code 11) writes A+1 with V=(A==0x7F). DEC (code 12) writes A-1 with V=(A==0x80). Both set Z and N and keep C and H.
- R9: LSR (code 13) shifts A right with 0 into bit 7. ROR (code 14) rotates A right with C into bit 7. ROL (code 15) rotates A left with C into bit 0. ASR (code 16) shifts A right and keeps bit 7. For ROL the new C is old bit 7; for the others it is old bit 0. All four set Z and N, set V = N XOR C and keep H.
- R10: SWAP (code 17) writes A with bits 7..4 and 3..0 exchanged and leaves the whole status byte unchanged.
- R11: FSET (code 18) and FCLR (code 19) write 1 or 0 to the status bit selected by `bit_sel`, leave the other seven bits alone and keep `result_we` at 0.
- R12: Codes 20 to 31 write nothing and leave the status byte unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_en | input | 1 | Execute the selected operation this cycle |
| op_sel | input | 5 | Operation code |
| opnd_a | input | 8 | First operand; the only operand for one-operand operations |
| opnd_b | input | 8 | Second operand |
| bit_sel | input | 3 | Status bit index for FSET and FCLR |
| result | output | 8 | Operation result, valid when `result_we` is high |
| result_we | output | 1 | The result is to be written back |
| status_next | output | 8 | Status byte after this operation |
| status_q | output | 8 | Current registered status byte |

## Verification
Some properties are checked on every cycle: which flags each class of operation may touch, the sticky zero of the with-carry subtractions, the single-bit reach of FSET and FCLR, the idle hold, the missing write for compares and flag operations, and the S=N^V rule. The bench alone can show that the numbers are right: sums and differences at the 0x7F/0x80 and 0xFF/0x00 boundaries, half-carry at nibble edges, the bits that enter through the rotates, and multi-byte carry chains through the registered status.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

  localparam int FLAG_N = 8;
  localparam int FLG_C = 0;
  localparam int FLG_Z = 1;
  localparam int FLG_N = 2;
  localparam int FLG_V = 3;
  localparam int FLG_S = 4;
  localparam int FLG_H = 5;
  localparam int FLG_T = 6;
  localparam int FLG_I = 7;

  localparam int OP_W = 5;

  typedef enum logic [OP_W-1:0] {
    OP_ADD  = 5'd0,
    OP_ADC  = 5'd1,
    OP_SUB  = 5'd2,
    OP_SBC  = 5'd3,
    OP_CP   = 5'd4,
    OP_CPC  = 5'd5,
    OP_AND  = 5'd6,
    OP_OR   = 5'd7,
    OP_XOR  = 5'd8,
    OP_COM  = 5'd9,
    OP_NEG  = 5'd10,
    OP_INC  = 5'd11,
    OP_DEC  = 5'd12,
    OP_LSR  = 5'd13,
    OP_ROR  = 5'd14,
    OP_ROL  = 5'd15,
    OP_ASR  = 5'd16,
    OP_SWAP = 5'd17,
    OP_FSET = 5'd18,
    OP_FCLR = 5'd19
  } alu_op_e;

endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
  parameter int W = 8
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic         cin,
  input  logic         is_sub,
  output logic [W-1:0] res,
  output logic         c_out,
  output logic         h_out,
  output logic         v_out
);
  localparam int HB = W / 2;

  function automatic logic [W:0] full_sum(input logic [W-1:0] p, input logic [W-1:0] q,
                                          input logic ci);
    return {1'b0, p} + {1'b0, q} + {{W{1'b0}}, ci};
  endfunction

  function automatic logic [HB:0] half_sum(input logic [HB-1:0] p, input logic [HB-1:0] q,
                                           input logic ci);
    return {1'b0, p} + {1'b0, q} + {{HB{1'b0}}, ci};
  endfunction

  function automatic logic sgn_ovf(input logic p_msb, input logic q_msb, input logic r_msb);
    return (p_msb == q_msb) && (r_msb != p_msb);
  endfunction

  logic [W-1:0]  y_eff;
  logic          c_eff;
  logic [W:0]    sum_w;
  logic [HB:0]   sum_h;

  assign y_eff = is_sub ? ~y : y;
  assign c_eff = is_sub ? ~cin : cin;
  assign sum_w = full_sum(x, y_eff, c_eff);
  assign sum_h = half_sum(x[HB-1:0], y_eff[HB-1:0], c_eff);

  assign res   = sum_w[W-1:0];
  assign c_out = is_sub ? ~sum_w[W] : sum_w[W];
  assign h_out = is_sub ? ~sum_h[HB] : sum_h[HB];
  assign v_out = sgn_ovf(x[W-1], y_eff[W-1], sum_w[W-1]);

endmodule

// File: rtl/alu8_bitops.sv
module alu8_bitops
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input  alu_op_e      op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] res,
  output logic         c_out,
  output logic         v_out
);
  localparam int HB = W / 2;

  function automatic logic [W-1:0] nib_swap(input logic [W-1:0] v);
    return {v[HB-1:0], v[W-1:HB]};
  endfunction

  function automatic logic [W-1:0] shr_fill(input logic [W-1:0] v, input logic fill);
    return {fill, v[W-1:1]};
  endfunction

  function automatic logic [W-1:0] shl_fill(input logic [W-1:0] v, input logic fill);
    return {v[W-2:0], fill};
  endfunction

  always_comb begin
    res   = a;
    c_out = cin;
    v_out = 1'b0;
    unique case (op)
      OP_AND:  res = a & b;
      OP_OR:   res = a | b;
      OP_XOR:  res = a ^ b;
      OP_COM: begin
        res   = ~a;
        c_out = 1'b1;
      end
      OP_INC: begin
        res   = a + 1'b1;
        v_out = (a == {1'b0, {(W-1){1'b1}}});
      end
      OP_DEC: begin
        res   = a - 1'b1;
        v_out = (a == {1'b1, {(W-1){1'b0}}});
      end
      OP_LSR: begin
        res   = shr_fill(a, 1'b0);
        c_out = a[0];
      end
      OP_ROR: begin
        res   = shr_fill(a, cin);
        c_out = a[0];
      end
      OP_ROL: begin
        res   = shl_fill(a, cin);
        c_out = a[W-1];
      end
      OP_ASR: begin
        res   = shr_fill(a, a[W-1]);
        c_out = a[0];
      end
      OP_SWAP: res = nib_swap(a);
      default: ;
    endcase
  end

endmodule

// File: rtl/alu8_status_unit.sv
module alu8_status_unit
  import alu8_pkg::*;
#(
  parameter int W     = 8,
  parameter int SEL_W = $clog2(alu8_pkg::FLAG_N)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                op_en,
  input  logic [OP_W-1:0]     op_sel,
  input  logic [W-1:0]        opnd_a,
  input  logic [W-1:0]        opnd_b,
  input  logic [SEL_W-1:0]    bit_sel,
  output logic [W-1:0]        result,
  output logic                result_we,
  output logic [FLAG_N-1:0]   status_next,
  output logic [FLAG_N-1:0]   status_q
);

  alu_op_e op;
  assign op = alu_op_e'(op_sel);

  // arithmetic path operand steering
  logic          arith_sub;
  logic          arith_cin;
  logic [W-1:0]  arith_x;
  logic [W-1:0]  arith_y;
  logic [W-1:0]  arith_res;
  logic          arith_c;
  logic          arith_h;
  logic          arith_v;

  always_comb begin
    arith_x   = opnd_a;
    arith_y   = opnd_b;
    arith_sub = 1'b1;
    arith_cin = 1'b0;
    unique case (op)
      OP_ADD: arith_sub = 1'b0;
      OP_ADC: begin
        arith_sub = 1'b0;
        arith_cin = status_q[FLG_C];
      end
      OP_SBC, OP_CPC: arith_cin = status_q[FLG_C];
      OP_NEG: begin
        arith_x = '0;
        arith_y = opnd_a;
      end
      default: ;
    endcase
  end

  alu8_addsub #(.W(W)) u_addsub (
    .x      (arith_x),
    .y      (arith_y),
    .cin    (arith_cin),
    .is_sub (arith_sub),
    .res    (arith_res),
    .c_out  (arith_c),
    .h_out  (arith_h),
    .v_out  (arith_v)
  );

  logic [W-1:0]  bit_res;
  logic          bit_c;
  logic          bit_v;

  alu8_bitops #(.W(W)) u_bitops (
    .op    (op),
    .a     (opnd_a),
    .b     (opnd_b),
    .cin   (status_q[FLG_C]),
    .res   (bit_res),
    .c_out (bit_c),
    .v_out (bit_v)
  );

  // named events for the checker
  logic                is_arith;
  logic                is_cmp;
  logic                is_shift;
  logic                is_flagop;
  logic                upd_nz;
  logic                sticky_z;
  logic                wr_ok;
  logic [W-1:0]        res_sel;
  logic                res_zero;
  logic [FLAG_N-1:0]   calc;

  always_comb begin
    is_arith  = 1'b0;
    is_cmp    = 1'b0;
    is_shift  = 1'b0;
    is_flagop = 1'b0;
    upd_nz    = 1'b0;
    sticky_z  = 1'b0;
    wr_ok     = 1'b0;
    unique case (op)
      OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_NEG: begin
        is_arith = 1'b1;
        upd_nz   = 1'b1;
        wr_ok    = 1'b1;
        sticky_z = (op == OP_SBC);
      end
      OP_CP, OP_CPC: begin
        is_arith = 1'b1;
        is_cmp   = 1'b1;
        upd_nz   = 1'b1;
        sticky_z = (op == OP_CPC);
      end
      OP_AND, OP_OR, OP_XOR, OP_COM, OP_INC, OP_DEC: begin
        upd_nz = 1'b1;
        wr_ok  = 1'b1;
      end
      OP_LSR, OP_ROR, OP_ROL, OP_ASR: begin
        is_shift = 1'b1;
        upd_nz   = 1'b1;
        wr_ok    = 1'b1;
      end
      OP_SWAP: wr_ok = 1'b1;
      OP_FSET, OP_FCLR: is_flagop = 1'b1;
      default: ;
    endcase
  end

  assign res_sel  = is_arith ? arith_res : bit_res;
  assign res_zero = (res_sel == '0);

  always_comb begin
    calc = status_q;
    if (is_arith) begin
      calc[FLG_C] = arith_c;
      calc[FLG_H] = arith_h;
      calc[FLG_V] = arith_v;
    end else if (is_shift) begin
      calc[FLG_C] = bit_c;
      calc[FLG_V] = res_sel[W-1] ^ bit_c;
    end else if (upd_nz) begin
      calc[FLG_C] = bit_c;
      calc[FLG_V] = bit_v;
    end
    if (upd_nz) begin
      calc[FLG_N] = res_sel[W-1];
      calc[FLG_Z] = sticky_z ? (res_zero & status_q[FLG_Z]) : res_zero;
      calc[FLG_S] = calc[FLG_N] ^ calc[FLG_V];
    end
    if (is_flagop)
      calc[bit_sel] = (op == OP_FSET);
  end

  assign result      = res_sel;
  assign result_we   = op_en & wr_ok;
  assign status_next = op_en ? calc : status_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      status_q <= '0;
    else if (op_en)
      status_q <= status_next;
  end

endmodule

// File: rtl/alu8_status_chk.sv
module alu8_status_chk
  import alu8_pkg::*;
(
  input logic                clk,
  input logic                rst_n,
  input logic                op_en,
  input logic [OP_W-1:0]     op_sel,
  input logic [2:0]          bit_sel,
  input logic                result_we,
  input logic [FLAG_N-1:0]   status_next,
  input logic [FLAG_N-1:0]   status_q,
  input logic                upd_nz
);

  // R1
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !op_en |=> $stable(status_q));

  // R2
  sign_rule_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_en && upd_nz) |-> (status_next[FLG_S] == (status_next[FLG_N] ^ status_next[FLG_V])));

  // R2
  it_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel != OP_FSET && op_sel != OP_FCLR) |-> (status_next[7:6] == status_q[7:6]));

  // R4
  sticky_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_en && (op_sel == OP_SBC || op_sel == OP_CPC) && !status_q[FLG_Z]) |-> !status_next[FLG_Z]);

  // R5
  cmp_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel == OP_CP || op_sel == OP_CPC) |-> !result_we);

  // R6
  logic_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_en && (op_sel == OP_AND || op_sel == OP_OR || op_sel == OP_XOR)) |->
      (!status_next[FLG_V] && status_next[FLG_C] == status_q[FLG_C] &&
       status_next[FLG_H] == status_q[FLG_H]));

  // R8
  incdec_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel == OP_INC || op_sel == OP_DEC) |->
      (status_next[FLG_C] == status_q[FLG_C] && status_next[FLG_H] == status_q[FLG_H]));

  // R10
  swap_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel == OP_SWAP) |-> (status_next == status_q));

  // R11
  flagop_reach_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_en && (op_sel == OP_FSET || op_sel == OP_FCLR)) |->
      ($countones(status_next ^ status_q) <= 1 &&
       status_next[bit_sel] == (op_sel == OP_FSET) && !result_we));

  // R12
  unused_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel > OP_FCLR) |-> (!result_we && status_next == status_q));

endmodule

bind alu8_status_unit alu8_status_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .op_en       (op_en),
  .op_sel      (op_sel),
  .bit_sel     (bit_sel),
  .result_we   (result_we),
  .status_next (status_next),
  .status_q    (status_q),
  .upd_nz      (upd_nz)
);

// File: tb/alu8_status_unit_test.sv
module alu8_status_unit_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       op_en = 1'b0;
  logic [4:0] op_sel = '0;
  logic [7:0] opnd_a = '0;
  logic [7:0] opnd_b = '0;
  logic [2:0] bit_sel = '0;
  logic [7:0] result;
  logic       result_we;
  logic [7:0] status_next;
  logic [7:0] status_q;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [7:0] model_st = 8'h00;

  always #10 clk = ~clk;

  alu8_status_unit uut (
    .clk(clk), .rst_n(rst_n), .op_en(op_en), .op_sel(op_sel),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .bit_sel(bit_sel),
    .result(result), .result_we(result_we),
    .status_next(status_next), .status_q(status_q)
  );

  function automatic string tag_of(input int op);
    if (op <= 1) return "R3";
    if (op <= 3) return "R4";
    if (op <= 5) return "R5";
    if (op <= 8) return "R6";
    if (op <= 10) return "R7";
    if (op <= 12) return "R8";
    if (op <= 16) return "R9";
    if (op == 17) return "R10";
    if (op <= 19) return "R11";
    return "R12";
  endfunction

  function automatic int sx(input int v);
    return (v > 127) ? v - 256 : v;
  endfunction

  // behavioural reference: integer arithmetic, flags from ranges
  task automatic ref_op(input bit en, input int op, input int a, input int b, input int bs,
                        input logic [7:0] st, output logic [7:0] r, output bit we,
                        output logic [7:0] ns);
    int c, x, sv, rv;
    bit tnz, sticky, shift;
    c = st[0]; ns = st; we = 0; r = 0; tnz = 0; sticky = 0; shift = 0; rv = 0;
    case (op)
      0, 1: begin
        if (op == 0) c = 0;
        x = a + b + c; rv = x % 256;
        ns[0] = (x > 255); ns[5] = ((a % 16) + (b % 16) + c) > 15;
        sv = sx(a) + sx(b) + c; ns[3] = (sv > 127) || (sv < -128);
        tnz = 1; we = 1;
      end
      2, 3, 4, 5, 10: begin
        int p, q;
        p = (op == 10) ? 0 : a; q = (op == 10) ? a : b;
        if (op == 2 || op == 4 || op == 10) c = 0;
        x = p - q - c; rv = (x + 512) % 256;
        ns[0] = (x < 0); ns[5] = ((p % 16) - (q % 16) - c) < 0;
        sv = sx(p) - sx(q) - c; ns[3] = (sv > 127) || (sv < -128);
        tnz = 1; sticky = (op == 3 || op == 5); we = (op != 4 && op != 5);
      end
      6: begin rv = a & b; ns[3] = 0; tnz = 1; we = 1; end
      7: begin rv = a | b; ns[3] = 0; tnz = 1; we = 1; end
      8: begin rv = a ^ b; ns[3] = 0; tnz = 1; we = 1; end
      9: begin rv = 255 - a; ns[0] = 1; ns[3] = 0; tnz = 1; we = 1; end
      11: begin rv = (a + 1) % 256; ns[3] = (a == 127); tnz = 1; we = 1; end
      12: begin rv = (a + 255) % 256; ns[3] = (a == 128); tnz = 1; we = 1; end
      13: begin rv = a / 2; ns[0] = a % 2; tnz = 1; shift = 1; we = 1; end
      14: begin rv = a / 2 + c * 128; ns[0] = a % 2; tnz = 1; shift = 1; we = 1; end
      15: begin rv = (a * 2) % 256 + c; ns[0] = a / 128; tnz = 1; shift = 1; we = 1; end
      16: begin rv = a / 2 + (a / 128) * 128; ns[0] = a % 2; tnz = 1; shift = 1; we = 1; end
      17: begin rv = (a % 16) * 16 + a / 16; we = 1; end
      18: ns[bs] = 1'b1;
      19: ns[bs] = 1'b0;
      default: ;
    endcase
    r = 8'(rv);
    if (tnz) begin
      ns[2] = r[7];
      ns[1] = sticky ? ((r == 0) && st[1]) : (r == 0);
      if (shift) ns[3] = ns[2] ^ ns[0];
      ns[4] = ns[2] ^ ns[3];
    end
    if (!en) begin we = 0; ns = st; end
  endtask

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic run_op(input bit en, input int op, input int a, input int b, input int bs);
    logic [7:0] er, ens;
    bit ewe;
    @(negedge clk);
    op_en = en; op_sel = 5'(op); opnd_a = 8'(a); opnd_b = 8'(b); bit_sel = 3'(bs);
    #2;
    ref_op(en, op, a, b, bs, model_st, er, ewe, ens);
    check(result_we == ewe, en ? tag_of(op) : "R1", "result_we", result_we, ewe);
    if (ewe) check(result == er, tag_of(op), "result", result, er);
    check(status_next == ens, en ? tag_of(op) : "R1", "status_next", status_next, ens);
    @(posedge clk);
    model_st = ens;
    #1;
    check(status_q == model_st, "R2", "status_q", status_q, model_st);
  endtask

  task automatic set_st(input logic [7:0] v);
    for (int i = 0; i < 8; i++) run_op(1, v[i] ? 18 : 19, 0, 0, i);
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    check(status_q == 8'h00, "R1", "reset status_q", status_q, 0);
    check(result_we == 1'b0, "R1", "reset result_we", result_we, 0);
    @(negedge clk); rst_n = 1'b1;

    // R3 add boundaries and carry chain
    run_op(1, 0, 8'h7F, 8'h01, 0);
    run_op(1, 0, 8'hFF, 8'h01, 0);
    run_op(1, 1, 8'h10, 8'h20, 0);   // ADC with C=1 from previous
    run_op(1, 0, 8'h08, 8'h08, 0);
    // R4 subtract, borrow, sticky Z
    run_op(1, 2, 8'h80, 8'h01, 0);
    run_op(1, 2, 8'h00, 8'h01, 0);
    run_op(1, 3, 8'h05, 8'h04, 0);   // C=1 in: 0 result, Z stays 0
    set_st(8'h02);
    run_op(1, 3, 8'h05, 8'h05, 0);   // Z=1, C=0: Z stays 1
    // R5 compares
    run_op(1, 4, 8'h33, 8'h33, 0);
    run_op(1, 4, 8'h10, 8'h20, 0);
    run_op(1, 5, 8'h00, 8'h00, 0);
    // R6 logic keeps C,H
    set_st(8'h21);
    run_op(1, 6, 8'hF0, 8'h0F, 0);
    run_op(1, 7, 8'h80, 8'h01, 0);
    run_op(1, 8, 8'hAA, 8'hAA, 0);
    // R7
    run_op(1, 9, 8'h00, 0, 0);
    run_op(1, 10, 8'h80, 0, 0);
    run_op(1, 10, 8'h00, 0, 0);
    run_op(1, 10, 8'h01, 0, 0);
    // R8
    set_st(8'h21);
    run_op(1, 11, 8'h7F, 0, 0);
    run_op(1, 12, 8'h80, 0, 0);
    run_op(1, 12, 8'h00, 0, 0);
    run_op(1, 11, 8'hFF, 0, 0);
    // R9 shifts and rotates
    set_st(8'h01);
    run_op(1, 14, 8'h02, 0, 0);
    run_op(1, 15, 8'h81, 0, 0);
    run_op(1, 13, 8'h01, 0, 0);
    run_op(1, 16, 8'h81, 0, 0);
    run_op(1, 15, 8'h40, 0, 0);
    // R10 swap
    set_st(8'hC3);
    run_op(1, 17, 8'hA5, 0, 0);
    // R11 flag ops
    run_op(1, 18, 0, 0, 7);
    run_op(1, 19, 0, 0, 0);
    run_op(1, 18, 0, 0, 6);
    // R12 unused codes
    run_op(1, 25, 8'h12, 8'h34, 0);
    run_op(1, 31, 8'hFF, 8'hFF, 0);
    // R1 idle
    run_op(0, 0, 8'hFF, 8'hFF, 0);
    run_op(0, 18, 0, 0, 3);

    for (int i = 0; i < 3000; i++)
      run_op($urandom_range(0, 7) != 0, $urandom_range(0, 31), $urandom_range(0, 255),
             $urandom_range(0, 255), $urandom_range(0, 7));

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule